// File: doc/BRIEF.md
# Dual-Mode PWM and Toggle Timer

This block is a timer built from two 8-bit count halves that can work apart or chain into one 16-bit counter. It drives two output pins, A and B, and raises two sticky event flags. Counting advances only on cycles where an external prescaled `tick` strobe is high. A small write-only register port selects one of four modes and loads the compare and duty values.

The four modes are:

- Mode 0: two separate 8-bit toggle timers.
- Mode 1: two free-running 8-bit PWM channels.
- Mode 2: a 16-bit toggle timer with an extra toggle on every low-byte compare hit.
- Mode 3: a 16-bit toggle timer whose low byte drives a PWM on pin B.

Compare and duty values are written into pending registers. They are copied to the active copies only at the counter's reload point, so a period or duty cycle never gets cut short. Stopping the timer or changing its mode restarts both halves from zero. It also forces both pins low.

Top module: `pwm_toggle_timer`

## Requirements
- R1: After synchronous reset, out_a, out_b and both irq bits are 0.
- R2: The counters change only on cycles with tick high. With tick low, no output toggles and no flag is set.
- R3: In mode 0 the low half counts 0..CMP_LO and the high half counts 0..CMP_HI. On a tick where a half equals its compare value, that half returns to 0 and toggles its pin (A for low, B for high). The first toggle comes at tick CMP+1 after start, and the period is CMP+1 ticks.
- R4: In mode 1 both halves run freely from 0 to 255. out_a is high while the low count is below DUTY_A, and out_b is high while the high count is below DUTY_B. A duty of 0 holds the pin low.
- R5: In mode 2 the halves form one 16-bit count that returns to 0 on the tick where it equals {CMP_HI,CMP_LO}, toggling out_a. out_b toggles on every tick where the low byte equals CMP_LO, whatever the high byte is.
- R6: In mode 3 the 16-bit count and out_a behave as in mode 2. out_b is high while the low byte is below DUTY_A.
- R7: Written compare and duty values take effect at the next reload point. In mode 0 that is the half's own match. In mode 1 it is the count 255→0 step. In modes 2 and 3, compares reload at the full match and DUTY_A reloads whenever the low byte rolls to 0. While the timer is stopped, the active copies follow the written values.
- R8: While run is 0, both outputs are low. Clearing run, or writing a different mode, returns both counters to 0 and both toggle states to low.
- R9: irq bit 0 (low event) and bit 1 (high or full event) are sticky. They are set by the tick that causes the event:
  - Low event: the low match in modes 0 and 2, the low wrap in mode 1, and a low-byte roll to 0 in mode 3.
  - High or full event: the high match in mode 0, the high wrap in mode 1, and the full match in modes 2 and 3.
  - Writing 1 to a bit at address 5 clears it; a set in the same cycle wins.
- R10: The register map is as follows:
  - Address 0 is control: mode in bits 1:0 and run in bit 2.
  - Address 1 is CMP_LO and address 2 is CMP_HI.
  - Address 3 is DUTY_A and address 4 is DUTY_B.
  - Address 5 is the flag clear.
  
  A write takes effect at the clock edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| out_a | output | 1 | Output pin A |
| out_b | output | 1 | Output pin B |
| irq | output | 2 | Sticky event flags {high/full, low} |

## Verification
Edges are counted from the edge that writes run=1, which is edge 0 and the clear edge. With tick high every cycle, that edge's counter value is k after edge k, and an event on the value held before edge k shows on the pins and flags right after edge k. Every register, flag and toggle result is therefore due at the falling edge that follows its edge, with no further delay. The driver queues each expected pin and flag state against an absolute edge number computed from this rule. The monitor compares at that falling edge. Writes that test shadow loading are placed at chosen edges, and the expected waveform changes only at the computed reload edge.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    typedef enum logic [1:0] {
        M_TWO8  = 2'd0,
        M_PWM2  = 2'd1,
        M_TOG16 = 2'd2,
        M_MIX16 = 2'd3
    } mode_e;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_CMPLO = 3'd1;
    localparam logic [2:0] ADDR_CMPHI = 3'd2;
    localparam logic [2:0] ADDR_DUTYA = 3'd3;
    localparam logic [2:0] ADDR_DUTYB = 3'd4;
    localparam logic [2:0] ADDR_FLAGS = 3'd5;
    localparam int         RUN_BIT    = 2;

    typedef struct packed {
        logic tog_a;
        logic tog_b;
        logic ev_lo;
        logic ev_hi;
    } evt_t;

endpackage

// File: rtl/ptt_regs.sv
module ptt_regs
    import ptt_pkg::*;
#(
    parameter int HW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [HW-1:0] wr_data,
    input  logic          set_lo,
    input  logic          set_hi,
    output logic          run,
    output mode_e         mode,
    output logic          mode_chg,
    output logic [HW-1:0] pend_cmp_lo,
    output logic [HW-1:0] pend_cmp_hi,
    output logic [HW-1:0] pend_duty_a,
    output logic [HW-1:0] pend_duty_b,
    output logic [1:0]    flags
);
    logic       ctrl_wr;
    logic [1:0] clr_mask;

    assign ctrl_wr  = wr_en && (wr_addr == AW'(ADDR_CTRL));
    assign mode_chg = ctrl_wr && (mode_e'(wr_data[1:0]) != mode);
    assign clr_mask = (wr_en && (wr_addr == AW'(ADDR_FLAGS))) ? wr_data[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            run         <= 1'b0;
            mode        <= M_TWO8;
            pend_cmp_lo <= '0;
            pend_cmp_hi <= '0;
            pend_duty_a <= '0;
            pend_duty_b <= '0;
            flags       <= 2'b00;
        end else begin
            flags <= (flags & ~clr_mask) | {set_hi, set_lo};
            if (wr_en) begin
                case (wr_addr)
                    AW'(ADDR_CTRL): begin
                        mode <= mode_e'(wr_data[1:0]);
                        run  <= wr_data[RUN_BIT];
                    end
                    AW'(ADDR_CMPLO): pend_cmp_lo <= wr_data;
                    AW'(ADDR_CMPHI): pend_cmp_hi <= wr_data;
                    AW'(ADDR_DUTYA): pend_duty_a <= wr_data;
                    AW'(ADDR_DUTYB): pend_duty_b <= wr_data;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ptt_core.sv
module ptt_core
    import ptt_pkg::*;
#(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clr,
    input  mode_e         mode,
    input  logic [HW-1:0] pend_cmp_lo,
    input  logic [HW-1:0] pend_cmp_hi,
    input  logic [HW-1:0] pend_duty_a,
    input  logic [HW-1:0] pend_duty_b,
    output logic [HW-1:0] lo_cnt,
    output logic [HW-1:0] hi_cnt,
    output logic [HW-1:0] act_cmp_lo,
    output logic [HW-1:0] act_cmp_hi,
    output logic [HW-1:0] act_duty_a,
    output logic [HW-1:0] act_duty_b,
    output evt_t          evt
);
    localparam int FW = 2 * HW;

    logic          lo_match, hi_match, full_match, lo_max, hi_max;
    logic [FW-1:0] full_nxt;
    logic [HW-1:0] nxt_lo, nxt_hi;
    logic          ld_cmp_lo, ld_cmp_hi, ld_duty_a, ld_duty_b;
    evt_t          raw;

    assign lo_match   = (lo_cnt == act_cmp_lo);
    assign hi_match   = (hi_cnt == act_cmp_hi);
    assign full_match = lo_match && hi_match;
    assign lo_max     = &lo_cnt;
    assign hi_max     = &hi_cnt;
    assign full_nxt   = full_match ? '0 : ({hi_cnt, lo_cnt} + 1'b1);

    always_comb begin
        nxt_lo    = lo_cnt;
        nxt_hi    = hi_cnt;
        ld_cmp_lo = 1'b0;
        ld_cmp_hi = 1'b0;
        ld_duty_a = 1'b0;
        ld_duty_b = 1'b0;
        raw       = '0;
        case (mode)
            M_TWO8: begin
                nxt_lo    = lo_match ? '0 : lo_cnt + 1'b1;
                nxt_hi    = hi_match ? '0 : hi_cnt + 1'b1;
                ld_cmp_lo = lo_match;
                ld_cmp_hi = hi_match;
                raw.tog_a = lo_match;
                raw.tog_b = hi_match;
                raw.ev_lo = lo_match;
                raw.ev_hi = hi_match;
            end
            M_PWM2: begin
                nxt_lo    = lo_cnt + 1'b1;
                nxt_hi    = hi_cnt + 1'b1;
                ld_duty_a = lo_max;
                ld_duty_b = hi_max;
                raw.ev_lo = lo_max;
                raw.ev_hi = hi_max;
            end
            M_TOG16: begin
                {nxt_hi, nxt_lo} = full_nxt;
                ld_cmp_lo = full_match;
                ld_cmp_hi = full_match;
                raw.tog_a = full_match;
                raw.tog_b = lo_match;
                raw.ev_lo = lo_match;
                raw.ev_hi = full_match;
            end
            default: begin
                {nxt_hi, nxt_lo} = full_nxt;
                ld_cmp_lo = full_match;
                ld_cmp_hi = full_match;
                ld_duty_a = full_match || lo_max;
                raw.tog_a = full_match;
                raw.ev_lo = full_match || lo_max;
                raw.ev_hi = full_match;
            end
        endcase
    end

    assign evt = (tick && !clr) ? raw : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt     <= '0;
            hi_cnt     <= '0;
            act_cmp_lo <= '0;
            act_cmp_hi <= '0;
            act_duty_a <= '0;
            act_duty_b <= '0;
        end else if (clr) begin
            lo_cnt     <= '0;
            hi_cnt     <= '0;
            act_cmp_lo <= pend_cmp_lo;
            act_cmp_hi <= pend_cmp_hi;
            act_duty_a <= pend_duty_a;
            act_duty_b <= pend_duty_b;
        end else if (tick) begin
            lo_cnt <= nxt_lo;
            hi_cnt <= nxt_hi;
            if (ld_cmp_lo) act_cmp_lo <= pend_cmp_lo;
            if (ld_cmp_hi) act_cmp_hi <= pend_cmp_hi;
            if (ld_duty_a) act_duty_a <= pend_duty_a;
            if (ld_duty_b) act_duty_b <= pend_duty_b;
        end
    end
endmodule

// File: rtl/ptt_outs.sv
module ptt_outs
    import ptt_pkg::*;
#(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    input  mode_e         mode,
    input  evt_t          evt,
    input  logic [HW-1:0] lo_cnt,
    input  logic [HW-1:0] hi_cnt,
    input  logic [HW-1:0] act_duty_a,
    input  logic [HW-1:0] act_duty_b,
    output logic          out_a,
    output logic          out_b
);
    logic tog_a, tog_b;
    logic pwm_lo, pwm_hi;
    logic pin_a, pin_b;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tog_a <= 1'b0;
            tog_b <= 1'b0;
        end else begin
            if (evt.tog_a) tog_a <= ~tog_a;
            if (evt.tog_b) tog_b <= ~tog_b;
        end
    end

    assign pwm_lo = (lo_cnt < act_duty_a);
    assign pwm_hi = (hi_cnt < act_duty_b);

    always_comb begin
        case (mode)
            M_PWM2:  begin pin_a = pwm_lo; pin_b = pwm_hi; end
            M_MIX16: begin pin_a = tog_a;  pin_b = pwm_lo; end
            default: begin pin_a = tog_a;  pin_b = tog_b;  end
        endcase
    end

    assign out_a = run && pin_a;
    assign out_b = run && pin_b;
endmodule

// File: rtl/pwm_toggle_timer.sv
module pwm_toggle_timer
    import ptt_pkg::*;
#(
    parameter int HW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [HW-1:0] wr_data,
    output logic          out_a,
    output logic          out_b,
    output logic [1:0]    irq
);
    logic          run, mode_chg, clr;
    mode_e         mode;
    logic [HW-1:0] pend_cmp_lo, pend_cmp_hi, pend_duty_a, pend_duty_b;
    logic [HW-1:0] lo_cnt, hi_cnt;
    logic [HW-1:0] act_cmp_lo, act_cmp_hi, act_duty_a, act_duty_b;
    evt_t          evt;

    assign clr = !run || mode_chg;

    ptt_regs #(.HW(HW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .set_lo(evt.ev_lo), .set_hi(evt.ev_hi), .run(run), .mode(mode),
        .mode_chg(mode_chg), .pend_cmp_lo(pend_cmp_lo), .pend_cmp_hi(pend_cmp_hi),
        .pend_duty_a(pend_duty_a), .pend_duty_b(pend_duty_b), .flags(irq)
    );

    ptt_core #(.HW(HW)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .clr(clr), .mode(mode),
        .pend_cmp_lo(pend_cmp_lo), .pend_cmp_hi(pend_cmp_hi),
        .pend_duty_a(pend_duty_a), .pend_duty_b(pend_duty_b),
        .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .act_cmp_lo(act_cmp_lo),
        .act_cmp_hi(act_cmp_hi), .act_duty_a(act_duty_a),
        .act_duty_b(act_duty_b), .evt(evt)
    );

    ptt_outs #(.HW(HW)) u_outs (
        .clk(clk), .rst(rst), .clr(clr), .run(run), .mode(mode), .evt(evt),
        .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .act_duty_a(act_duty_a),
        .act_duty_b(act_duty_b), .out_a(out_a), .out_b(out_b)
    );
endmodule

// File: rtl/ptt_chk.sv
module ptt_chk
    import ptt_pkg::*;
#(
    parameter int HW = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          clr,
    input logic          run,
    input mode_e         mode,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [HW-1:0] wr_data,
    input logic [HW-1:0] lo_cnt,
    input logic [HW-1:0] hi_cnt,
    input logic [HW-1:0] act_cmp_lo,
    input logic [HW-1:0] act_duty_a,
    input logic          out_a,
    input logic [1:0]    irq
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == AW'(ADDR_CTRL));

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> ($stable(lo_cnt) && $stable(hi_cnt))); // R2

    AST_M0_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (run && !ctrl_wr && tick && mode == M_TWO8 && lo_cnt == act_cmp_lo)
        |=> (out_a != $past(out_a))); // R3

    AST_PWM_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == M_PWM2 && act_duty_a == '0) |-> !out_a); // R4

    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
        clr |=> (lo_cnt == '0 && hi_cnt == '0)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq[0] && !(wr_en && wr_addr == AW'(ADDR_FLAGS) && wr_data[0])) |=> irq[0]); // R9
endmodule

bind pwm_toggle_timer ptt_chk #(.HW(HW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .clr(clr), .run(run), .mode(mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .lo_cnt(lo_cnt),
    .hi_cnt(hi_cnt), .act_cmp_lo(act_cmp_lo), .act_duty_a(act_duty_a),
    .out_a(out_a), .irq(irq)
);

// File: tb/sim_pwm_toggle_timer.sv
module sim_pwm_toggle_timer;
    import ptt_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       out_a, out_b;
    logic [1:0] irq;

    int unsigned cyc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    typedef struct packed {
        int unsigned at;
        logic        a;
        logic        b;
        logic [1:0]  q;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  e_cur;
    string t_cur;

    pwm_toggle_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_a(out_a), .out_b(out_b), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(string tag, logic a, logic b, logic [1:0] q);
        checks++;
        if (out_a !== a || out_b !== b || irq !== q) begin
            fails++;
            $display("FAIL %s edge %0d: got a=%b b=%b irq=%b, expected a=%b b=%b irq=%b",
                     tag, cyc, out_a, out_b, irq, a, b, q);
        end
    endtask

    task automatic push(int unsigned at, bit a, bit b, bit [1:0] q, string tag);
        exp_t e;
        e.at = at; e.a = a; e.b = b; e.q = q;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares queued expectations at the falling edge they are due
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            e_cur = exp_q.pop_front();
            t_cur = tag_q.pop_front();
            compare(t_cur, e_cur.a, e_cur.b, e_cur.q);
        end
    end

    task automatic wait_until(int unsigned t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_at(int unsigned edge_no, logic [2:0] a, logic [7:0] d);
        wait_until(edge_no - 1);
        wr(a, d);
    endtask

    task automatic stop_and_clear();
        wr(ADDR_CTRL, 8'h00);
        wr(ADDR_FLAGS, 8'h03);
    endtask

    initial begin
        int unsigned r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1", 1'b0, 1'b0, 2'b00);

        // R3, R10: mode 0, CMP_LO=3 (period 4), CMP_HI=5 (period 6)
        wr(ADDR_CMPLO, 8'd3);
        wr(ADDR_CMPHI, 8'd5);
        wr(ADDR_CTRL, 8'h04);
        r = cyc;
        for (int k = 1; k <= 24; k++)
            push(r + k, ((k / 4) % 2) == 1, ((k / 6) % 2) == 1, {k >= 6, k >= 4}, "R3 R10");
        wait_until(r + 24);

        // R8: mode change clears toggle state; stopping forces pins low
        wr(ADDR_CTRL, 8'h06);
        compare("R8", 1'b0, 1'b0, 2'b11);
        wr(ADDR_CTRL, 8'h00);
        compare("R8", 1'b0, 1'b0, 2'b11);
        // R9: write-one-to-clear per bit
        wr(ADDR_FLAGS, 8'h01);
        compare("R9", 1'b0, 1'b0, 2'b10);
        wr(ADDR_FLAGS, 8'h02);
        compare("R9", 1'b0, 1'b0, 2'b00);

        // R7: new CMP_LO written mid-period loads only at next match
        wr(ADDR_CMPLO, 8'd3);
        wr(ADDR_CMPHI, 8'd200);
        wr(ADDR_CTRL, 8'h04);
        r = cyc;
        for (int k = 1; k <= 10; k++)
            push(r + k, (k >= 4 && k < 6) || (k >= 8 && k < 10), 1'b0, {1'b0, k >= 4}, "R7");
        wr_at(r + 2, ADDR_CMPLO, 8'd1);
        wait_until(r + 10);
        stop_and_clear();

        // R2: no counting while tick is low
        wr(ADDR_CMPLO, 8'd1);
        wr(ADDR_CMPHI, 8'd0);
        tick = 1'b0;
        wr(ADDR_CTRL, 8'h04);
        r = cyc;
        for (int k = 1; k <= 8; k++) push(r + k, 1'b0, 1'b0, 2'b00, "R2");
        wait_until(r + 8);
        for (int j = 1; j <= 6; j++)
            push(r + 8 + j, ((j / 2) % 2) == 1, (j % 2) == 1, {1'b1, j >= 2}, "R2");
        tick = 1'b1;
        wait_until(r + 14);
        stop_and_clear();

        // R4, R7: mode 1 PWM, duty A 64 -> 200 and duty B 0 -> 128 at wrap
        wr(ADDR_DUTYA, 8'd64);
        wr(ADDR_DUTYB, 8'd0);
        wr(ADDR_CTRL, 8'h05);
        r = cyc;
        for (int k = 1; k <= 300; k++)
            push(r + k,
                 (k < 256) ? ((k % 256) < 64) : ((k % 256) < 200),
                 (k < 256) ? 1'b0 : ((k % 256) < 128),
                 (k >= 256) ? 2'b11 : 2'b00, "R4 R7");
        wr_at(r + 10, ADDR_DUTYA, 8'd200);
        wr_at(r + 20, ADDR_DUTYB, 8'd128);
        wait_until(r + 300);
        stop_and_clear();

        // R5: mode 2, full compare 0x0102, low-byte compare 2
        wr(ADDR_CMPLO, 8'd2);
        wr(ADDR_CMPHI, 8'd1);
        wr(ADDR_CTRL, 8'h06);
        r = cyc;
        for (int k = 1; k <= 270; k++)
            push(r + k, k >= 259, (k >= 3 && k < 259) || k >= 262, {k >= 259, k >= 3}, "R5");
        wait_until(r + 270);
        stop_and_clear();

        // R6: mode 3, full compare 0x0104, low-byte PWM duty 100
        wr(ADDR_CMPLO, 8'd4);
        wr(ADDR_CMPHI, 8'd1);
        wr(ADDR_DUTYA, 8'd100);
        wr(ADDR_CTRL, 8'h07);
        r = cyc;
        for (int k = 1; k <= 280; k++)
            push(r + k, k >= 261,
                 (((k < 261) ? k : (k - 261)) % 256) < 100,
                 {k >= 261, k >= 256}, "R6");
        wait_until(r + 281);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule